// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Controller

This block moves serial words of 1 to 16 bits. As bus master it generates the serial clock, shifts data out MSB first and samples the returned data. As slave it takes clock, data and a select line from outside. Software reaches it through four halfword registers on a simple write-strobe bus. Reads are combinational.

The master side has two ways to control the select pin. In manual mode the pin follows a control bit, so the pin can also serve as a plain output. In interval mode a small sequencer does the work: it asserts the select, runs one transfer, releases the select, waits a programmed number of reference cycles, and repeats for as long as the block stays enabled. A separate general-purpose pin mirrors one control bit. In slave mode the external clock, data and select are resampled on the reference clock. The external clock must therefore stay at or below one sixteenth of the reference clock.

Top module: `spi_dual_ctrl`

## Requirements
- R1: After reset every register reads zero, and `gp_o`, `sck_oe` and `en_oe` are low.
- R2: The register index is `bus_addr[2:1]` (with `bus_addr[3]` and `bus_addr[0]` zero).
  - Index 0 is data: a write loads the transmit word and a read returns the last received word.
  - Index 1 is control and index 2 is the delay count; both read back exactly what was written.
  - Index 3 is status: bit 0 is done, bit 1 is busy.
- R3: The control fields are: run bit 0, master bit 1, interval bit 2, clock polarity bit 3, clock phase bit 4, select sense bit 5, general-purpose bit 6, bit count minus one in bits 11:8, manual select bit 12, and divider in bits 15:13. `gp_o` always equals control bit 6.
- R4: In master mode without interval, `en_oe` is high and `en_o` follows control bit 12. `en_o` equals bit 12 when sense is 1 and its inverse when sense is 0.
- R5: Writing the data register while run and master are set and interval is clear starts a transfer. The transfer toggles `sck_o` exactly twice per bit. Each level lasts divider+1 reference cycles, and `sck_o` rests at the polarity level when idle.
- R6: `sdo_o` carries the transmit word MSB first.
  - With phase 0 the master samples `mst_din_i` on leading edges and changes `sdo_o` on trailing edges.
  - With phase 1 it changes `sdo_o` on leading edges after the first and samples on trailing edges.
  - The data register then reads the received bits right-aligned, with the upper bits zero.
- R7: Status busy is high while a transfer runs. Status done sets when a transfer ends and clears when 1 is written to status bit 0.
- R8: In interval mode (run, master and interval all set), `en_o` is driven by the sequencer regardless of bit 12.
  - It is active for one transfer of the programmed length.
  - It then stays inactive for delay+1 reference cycles.
  - It then becomes active again for the next transfer.
- R9: In slave mode (run set, master clear) with `en_n_i` low, `slv_din_i` is shifted in on leading `sck_i` edges with phase 0 and on trailing edges with phase 1. After bit-count bits the data register holds the word and done sets.
- R10: In slave mode, clock edges while `en_n_i` is high shift nothing and set nothing. Raising `en_n_i` mid-word discards the partial word, so the next selected word is received intact.
- R11: A data write during a running master transfer does not restart or lengthen that transfer, and does not change the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| sck_o | output | 1 | Master serial clock |
| sck_oe | output | 1 | Serial clock output enable (master mode) |
| sck_i | input | 1 | Slave serial clock |
| sdo_o | output | 1 | Master serial data out |
| mst_din_i | input | 1 | Master serial data in |
| slv_din_i | input | 1 | Slave serial data in |
| en_o | output | 1 | Master select output |
| en_oe | output | 1 | Select output enable (master mode) |
| en_n_i | input | 1 | Slave select input, active low |
| gp_o | output | 1 | General-purpose output |

## Verification
An edge counter or divider that is off by one shows up at once on `sck_o`: the transfer has the wrong number of toggles, or the levels have the wrong width. A bad shift-point choice corrupts `sdo_o` within the first bit period. It also corrupts the received word, which becomes visible on the first data read after done.

Sequencer faults show as a wrong select gap within one transfer period. A slave bit counter that is not cleared by the select line only becomes visible one full word later, as a misaligned received value.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned NB_W   = 4;

  typedef struct packed {
    logic [2:0]      div;
    logic            man_en;
    logic [NB_W-1:0] nbits_m1;
    logic            spare;
    logic            gp;
    logic            sns;
    logic            cpha;
    logic            cpol;
    logic            interval;
    logic            master;
    logic            run;
  } ctrl_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_XFER, SQ_GAP} seq_state_t;
  typedef enum logic [1:0] {RA_DATA = 2'd0, RA_CTRL = 2'd1, RA_IVL = 2'd2, RA_STAT = 2'd3} reg_idx_t;

  // reference cycles per serial clock level
  function automatic logic [3:0] half_len(input logic [2:0] div);
    return {1'b0, div} + 4'd1;
  endfunction

  // place the first bit to send at the top of the word
  function automatic logic [WORD_W-1:0] msb_align(input logic [WORD_W-1:0] w,
                                                  input logic [NB_W-1:0] nm1);
    return w << (4'd15 - nm1);
  endfunction

  // ones in the low nm1+1 bits
  function automatic logic [WORD_W-1:0] low_mask(input logic [NB_W-1:0] nm1);
    logic [WORD_W:0] t;
    t = (17'd1 << ({1'b0, nm1} + 5'd1)) - 17'd1;
    return t[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/spi_regs.sv
module spi_regs
  import spi_dual_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output ctrl_t             ctrl,
  output logic [DLY_W-1:0]  delay,
  output logic [WORD_W-1:0] tx_word,
  output logic              data_wr_q,
  input  logic              xfer_done,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              busy,
  output logic              st_done
);
  logic [WORD_W-1:0] rx_q;
  logic [WORD_W-1:0] dly_rd;
  reg_idx_t          idx;
  logic              hit;

  assign idx = reg_idx_t'(bus_addr[2:1]);
  assign hit = !bus_addr[3] && !bus_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      delay     <= '0;
      tx_word   <= '0;
      rx_q      <= '0;
      st_done   <= 1'b0;
      data_wr_q <= 1'b0;
    end else begin
      data_wr_q <= bus_wr && hit && (idx == RA_DATA);
      if (bus_wr && hit) begin
        case (idx)
          RA_DATA: tx_word <= bus_wdata;
          RA_CTRL: ctrl    <= ctrl_t'(bus_wdata);
          RA_IVL:  delay   <= bus_wdata[DLY_W-1:0];
          default: ;
        endcase
      end
      if (xfer_done) rx_q <= rx_word;
      if (xfer_done) st_done <= 1'b1;
      else if (bus_wr && hit && (idx == RA_STAT) && bus_wdata[0]) st_done <= 1'b0;
    end
  end

  always_comb begin
    dly_rd = '0;
    dly_rd[DLY_W-1:0] = delay;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (idx)
        RA_DATA: bus_rdata = rx_q;
        RA_CTRL: bus_rdata = ctrl;
        RA_IVL:  bus_rdata = dly_rd;
        RA_STAT: bus_rdata = {14'd0, busy, st_done};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_master_eng.sv
module spi_master_eng
  import spi_dual_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [NB_W-1:0]   nbits_m1,
  input  logic [2:0]        div,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              din,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              dout,
  output logic [WORD_W-1:0] rx_sh
);
  logic [3:0]        hcnt;
  logic [NB_W:0]     ecnt;
  logic              sck_q;
  logic [WORD_W-1:0] tx_sh;
  logic              tick, lead, last, smp, shf;

  assign tick = busy && (hcnt == (half_len(div) - 4'd1));
  assign lead = ~ecnt[0];
  assign last = (ecnt == {nbits_m1, 1'b1});
  assign smp  = tick && (lead ^ cpha);
  assign shf  = tick && (cpha ? (lead && (ecnt != '0)) : !lead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      hcnt  <= '0;
      ecnt  <= '0;
      sck_q <= 1'b0;
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      done <= tick && last;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          hcnt  <= '0;
          ecnt  <= '0;
          sck_q <= cpol;
          tx_sh <= msb_align(tx_word, nbits_m1);
        end
      end else if (tick) begin
        hcnt  <= '0;
        sck_q <= ~sck_q;
        ecnt  <= ecnt + 5'd1;
        if (last) busy <= 1'b0;
        if (smp) rx_sh <= {rx_sh[WORD_W-2:0], din};
        if (shf) tx_sh <= tx_sh << 1;
      end else begin
        hcnt <= hcnt + 4'd1;
      end
    end
  end

  assign sck  = busy ? sck_q : cpol;
  assign dout = tx_sh[WORD_W-1];
endmodule

// File: rtl/spi_interval_seq.sv
module spi_interval_seq
  import spi_dual_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             xfer_done,
  input  logic [DLY_W-1:0] delay,
  output logic             start,
  output logic             en_act,
  output logic             in_gap
);
  seq_state_t       st;
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (active) st <= SQ_LEAD;
        SQ_LEAD: st <= SQ_XFER;
        SQ_XFER: if (xfer_done) begin
          st  <= SQ_GAP;
          cnt <= '0;
        end
        SQ_GAP: begin
          if (!active)           st <= SQ_IDLE;
          else if (cnt == delay) st <= SQ_LEAD;
          else                   cnt <= cnt + DLY_W'(1);
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign start  = (st == SQ_LEAD);
  assign en_act = (st == SQ_LEAD) || (st == SQ_XFER);
  assign in_gap = (st == SQ_GAP);
endmodule

// File: rtl/spi_slave_rx.sv
module spi_slave_rx
  import spi_dual_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [NB_W-1:0]   nbits_m1,
  input  logic              sck_i,
  input  logic              din_i,
  input  logic              sel_n_i,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_sh,
  output logic [NB_W-1:0]   bitcnt
);
  logic [SYNC-1:0] sck_p, din_p, sel_p;
  logic            sck_s, sck_d, rise, fall, cap_ev, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      din_p <= '0;
      sel_p <= '1;
    end else begin
      sck_p <= {sck_p[SYNC-2:0], sck_i};
      din_p <= {din_p[SYNC-2:0], din_i};
      sel_p <= {sel_p[SYNC-2:0], sel_n_i};
    end
  end

  assign sck_s  = sck_p[SYNC-1];
  assign rise   = sck_s && !sck_d;
  assign fall   = !sck_s && sck_d;
  assign cap_ev = cpha ? (cpol ? rise : fall) : (cpol ? fall : rise);
  assign active = enable && !sel_p[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      done   <= 1'b0;
      bitcnt <= '0;
      rx_sh  <= '0;
    end else begin
      sck_d <= sck_s;
      done  <= 1'b0;
      if (!active) begin
        bitcnt <= '0;
      end else if (cap_ev) begin
        rx_sh <= {rx_sh[WORD_W-2:0], din_p[SYNC-1]};
        if (bitcnt >= nbits_m1) begin
          bitcnt <= '0;
          done   <= 1'b1;
        end else begin
          bitcnt <= bitcnt + 4'd1;
        end
      end
    end
  end

  assign busy = active && (bitcnt != '0);
endmodule

// File: rtl/spi_dual_ctrl.sv
module spi_dual_ctrl
  import spi_dual_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sck_o,
  output logic        sck_oe,
  input  logic        sck_i,
  output logic        sdo_o,
  input  logic        mst_din_i,
  input  logic        slv_din_i,
  output logic        en_o,
  output logic        en_oe,
  input  logic        en_n_i,
  output logic        gp_o
);
  ctrl_t             ctrl_q;
  logic [DLY_W-1:0]  delay;
  logic [WORD_W-1:0] tx_word, m_rx, s_rx, rx_word;
  logic              data_wr_q, st_done, xfer_done;
  logic              cfg_run, cfg_master, cfg_interval, cfg_cpol, cfg_cpha, cfg_sns;
  logic [NB_W-1:0]   nbits_m1, s_bitcnt;
  logic              m_busy, m_done, m_start, man_start;
  logic              s_busy, s_done;
  logic              seq_start, seq_en, seq_gap, seq_active, sel_act;

  assign cfg_run      = ctrl_q.run;
  assign cfg_master   = ctrl_q.master;
  assign cfg_interval = ctrl_q.interval;
  assign cfg_cpol     = ctrl_q.cpol;
  assign cfg_cpha     = ctrl_q.cpha;
  assign cfg_sns      = ctrl_q.sns;
  assign nbits_m1     = ctrl_q.nbits_m1;

  spi_regs #(.DLY_W(DLY_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl(ctrl_q), .delay(delay),
    .tx_word(tx_word), .data_wr_q(data_wr_q), .xfer_done(xfer_done),
    .rx_word(rx_word), .busy(m_busy || s_busy), .st_done(st_done)
  );

  assign seq_active = cfg_run && cfg_master && cfg_interval;
  assign man_start  = data_wr_q && cfg_run && cfg_master && !cfg_interval;
  assign m_start    = man_start || seq_start;

  spi_interval_seq #(.DLY_W(DLY_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .active(seq_active), .xfer_done(m_done),
    .delay(delay), .start(seq_start), .en_act(seq_en), .in_gap(seq_gap)
  );

  spi_master_eng i_mst (
    .clk(clk), .rst_n(rst_n), .start(m_start), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .nbits_m1(nbits_m1), .div(ctrl_q.div), .tx_word(tx_word), .din(mst_din_i),
    .busy(m_busy), .done(m_done), .sck(sck_o), .dout(sdo_o), .rx_sh(m_rx)
  );

  spi_slave_rx #(.SYNC(SYNC_STAGES)) i_slv (
    .clk(clk), .rst_n(rst_n), .enable(cfg_run && !cfg_master), .cpol(cfg_cpol),
    .cpha(cfg_cpha), .nbits_m1(nbits_m1), .sck_i(sck_i), .din_i(slv_din_i),
    .sel_n_i(en_n_i), .busy(s_busy), .done(s_done), .rx_sh(s_rx), .bitcnt(s_bitcnt)
  );

  assign xfer_done = m_done || s_done;
  assign rx_word   = (m_done ? m_rx : s_rx) & low_mask(nbits_m1);

  assign sel_act = cfg_interval ? seq_en : ctrl_q.man_en;
  assign en_o    = cfg_master && (cfg_sns ? sel_act : !sel_act);
  assign en_oe   = cfg_master;
  assign sck_oe  = cfg_master;
  assign gp_o    = ctrl_q.gp;
endmodule

// File: rtl/spi_dual_chk.sv
module spi_dual_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_master,
  input logic       cfg_interval,
  input logic       cfg_cpol,
  input logic       cfg_sns,
  input logic       sck_o,
  input logic       en_o,
  input logic       m_busy,
  input logic       m_done,
  input logic       s_done,
  input logic       st_done,
  input logic       seq_gap,
  input logic [3:0] s_bitcnt,
  input logic [3:0] nbits_m1
);
  // R5: the serial clock moves only while a transfer runs
  a_r5_sck_moves_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && $stable(cfg_cpol) && !$stable(sck_o)) |-> $past(m_busy));

  // R7: completion is reported right after the engine leaves busy
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |-> (!m_busy && $past(m_busy)));

  // R7: the status flag only rises after a completion pulse
  a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $past(m_done || s_done));

  // R8: during the gap the select sits at its inactive level
  a_r8_gap_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && cfg_interval && seq_gap) |-> (en_o == !cfg_sns));

  // R9: the slave bit counter stays inside the word
  a_r9_bitcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(nbits_m1) |-> (s_bitcnt <= nbits_m1));
endmodule

bind spi_dual_ctrl spi_dual_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_interval(cfg_interval),
  .cfg_cpol(cfg_cpol), .cfg_sns(cfg_sns), .sck_o(sck_o), .en_o(en_o),
  .m_busy(m_busy), .m_done(m_done), .s_done(s_done), .st_done(st_done),
  .seq_gap(seq_gap), .s_bitcnt(s_bitcnt), .nbits_m1(nbits_m1)
);

// File: tb/test_spi_dual_ctrl.sv
`timescale 1ns/1ps
module test_spi_dual_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        sck_o, sck_oe, sdo_o, en_o, en_oe, gp_o;
  logic        sck_i = 1'b0, mst_din_i = 1'b0, slv_din_i = 1'b0, en_n_i = 1'b1;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;
  localparam int H = 10;

  always #2.5 clk = ~clk;

  spi_dual_ctrl i_spi_dual_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o), .sck_oe(sck_oe),
    .sck_i(sck_i), .sdo_o(sdo_o), .mst_din_i(mst_din_i), .slv_din_i(slv_din_i),
    .en_o(en_o), .en_oe(en_oe), .en_n_i(en_n_i), .gp_o(gp_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_ctrl(bit run, bit mst, bit ivl, bit cpol, bit cpha, bit sns,
                                          bit gp, logic [3:0] nm1, bit man, logic [2:0] div);
    return {div, man, nm1, 1'b0, gp, sns, cpha, cpol, ivl, mst, run};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(4'(2 * i), v);
      chk(v == 16'h0, "R1", "register after reset", v, 0);
    end
    chk(gp_o == 0 && sck_oe == 0 && en_oe == 0, "R1", "pins after reset",
        {gp_o, sck_oe, en_oe}, 0);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(4'h2, 16'h1F3C); rd(4'h2, v);
    chk(v == 16'h1F3C, "R2", "control readback", v, 16'h1F3C);
    wr(4'h4, 16'hBEEF); rd(4'h4, v);
    chk(v == 16'hBEEF, "R2", "delay readback", v, 16'hBEEF);
    wr(4'h2, mk_ctrl(0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
    chk(gp_o == 1'b1, "R3", "gp high", gp_o, 1);
    wr(4'h2, 16'h0);
    chk(gp_o == 1'b0, "R3", "gp low", gp_o, 0);
  endtask

  task automatic t_manual_en;
    wr(4'h2, mk_ctrl(0, 1, 0, 0, 0, 1, 0, 0, 1, 0));
    chk(en_o == 1 && en_oe == 1, "R4", "sense1 bit12=1", {en_oe, en_o}, 3);
    wr(4'h2, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0, 1, 0));
    chk(en_o == 0, "R4", "sense0 bit12=1", en_o, 0);
    wr(4'h2, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    chk(en_o == 1, "R4", "sense0 bit12=0", en_o, 1);
  endtask

  task automatic t_master(input bit cpol, input bit cpha, input int nb, input logic [2:0] div,
                          input logic [15:0] tx, input logic [15:0] pat, input int poke);
    logic [15:0] v, cap, msk;
    int edges = 0, last = -1, idx;
    bit bad_half = 0, busy_seen = 0, prev, lead;
    msk = 16'((17'd1 << nb) - 1);
    wr(4'h2, mk_ctrl(1, 1, 0, cpol, cpha, 0, 0, 4'(nb - 1), 0, div));
    chk(sck_o == cpol, "R5", "idle clock level", sck_o, cpol);
    cap = 0;
    if (!cpha) begin mst_din_i = pat[nb-1]; idx = nb - 2; end
    else idx = nb - 1;
    wr(4'h0, tx);
    bus_addr = 4'h6;
    prev = sck_o;
    for (int cyc = 0; cyc < 2 * nb * (int'(div) + 1) + 12; cyc++) begin
      @(negedge clk);
      if (cyc == poke) begin bus_addr = 4'h0; bus_wdata = 16'hFFFF; bus_wr = 1'b1; end
      else if (cyc == poke + 1) begin bus_wr = 1'b0; bus_addr = 4'h6; end
      else begin #1; if (bus_rdata[1]) busy_seen = 1; end
      if (sck_o != prev) begin
        edges++;
        if (last >= 0 && cyc - last != int'(div) + 1) bad_half = 1;
        last = cyc;
        lead = (sck_o != cpol);
        if (lead ^ cpha) cap = {cap[14:0], sdo_o};
        else if (idx >= 0) begin mst_din_i = pat[idx]; idx--; end
        prev = sck_o;
      end
    end
    chk(edges == 2 * nb, "R5", "clock edge count", edges, 2 * nb);
    chk(!bad_half, "R5", "level width", bad_half, 0);
    chk(sck_o == cpol, "R5", "clock returns idle", sck_o, cpol);
    chk((cap & msk) == (tx & msk), poke >= 0 ? "R11" : "R6", "bits sent", cap & msk, tx & msk);
    chk(busy_seen, "R7", "busy seen", busy_seen, 1);
    rd(4'h6, v);
    chk(v[0] == 1, "R7", "done set", v[0], 1);
    rd(4'h0, v);
    chk(v == (pat & msk), "R6", "received word", v, pat & msk);
    wr(4'h6, 16'h1); rd(4'h6, v);
    chk(v[0] == 0, "R7", "done cleared", v[0], 0);
  endtask

  task automatic t_interval;
    int r1 = -1, f1 = -1, r2 = -1, rises = 0;
    bit pe = 0, ps = 0;
    logic [15:0] v;
    wr(4'h4, 16'd5);
    wr(4'h0, 16'h0009);
    wr(4'h2, mk_ctrl(1, 1, 1, 0, 0, 1, 0, 4'd3, 0, 0));
    for (int cyc = 0; cyc < 120; cyc++) begin
      @(negedge clk);
      if (en_o && !pe) begin if (r1 < 0) r1 = cyc; else if (r2 < 0 && f1 >= 0) r2 = cyc; end
      if (!en_o && pe && f1 < 0) f1 = cyc;
      if (sck_o && !ps && r1 >= 0 && f1 < 0) rises++;
      pe = en_o; ps = sck_o;
    end
    chk(r1 >= 0 && f1 > r1, "R8", "enable window", f1, r1);
    chk(rises == 4, "R8", "pulses in window", rises, 4);
    chk(r2 - f1 == 6, "R8", "gap length", r2 - f1, 6);
    wr(4'h2, 16'h0);
    repeat (40) @(negedge clk);
    rd(4'h6, v);
    chk(v[0] == 1, "R7", "done after interval run", v[0], 1);
    wr(4'h6, 16'h1);
  endtask

  task automatic slave_bits(input bit cpol, input bit cpha, input int nb, input logic [15:0] val);
    for (int i = nb - 1; i >= 0; i--) begin
      if (!cpha) begin
        slv_din_i = val[i]; repeat (H) @(negedge clk);
        sck_i = ~cpol;      repeat (H) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol; slv_din_i = val[i]; repeat (H) @(negedge clk);
        sck_i = cpol;       repeat (H) @(negedge clk);
      end
    end
  endtask

  task automatic t_slave;
    logic [15:0] v;
    wr(4'h2, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 4'd7, 0, 0));
    sck_i = 0; en_n_i = 0; repeat (5) @(negedge clk);
    slave_bits(0, 0, 8, 16'hC6);
    repeat (8) @(negedge clk); en_n_i = 1;
    rd(4'h0, v); chk(v == 16'h00C6, "R9", "slave word phase0", v, 16'hC6);
    rd(4'h6, v); chk(v[0] == 1, "R9", "slave done", v[0], 1);
    wr(4'h6, 16'h1);
    sck_i = 1;
    wr(4'h2, mk_ctrl(1, 0, 0, 1, 1, 0, 0, 4'd5, 0, 0));
    repeat (5) @(negedge clk); en_n_i = 0; repeat (5) @(negedge clk);
    slave_bits(1, 1, 6, 16'h2D);
    repeat (8) @(negedge clk); en_n_i = 1;
    rd(4'h0, v); chk(v == 16'h002D, "R9", "slave word phase1 pol1", v, 16'h2D);
    wr(4'h6, 16'h1);
    wr(4'h2, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 4'd7, 0, 0));
    sck_i = 0; repeat (5) @(negedge clk);
    slave_bits(0, 0, 8, 16'hFF);
    repeat (8) @(negedge clk);
    rd(4'h6, v); chk(v[0] == 0, "R10", "no done while deselected", v[0], 0);
    rd(4'h0, v); chk(v == 16'h002D, "R10", "data kept while deselected", v, 16'h2D);
    en_n_i = 0; repeat (5) @(negedge clk);
    slave_bits(0, 0, 3, 16'h7);
    repeat (8) @(negedge clk); en_n_i = 1; repeat (8) @(negedge clk);
    en_n_i = 0; repeat (5) @(negedge clk);
    slave_bits(0, 0, 8, 16'h5A);
    repeat (8) @(negedge clk); en_n_i = 1;
    rd(4'h0, v); chk(v == 16'h005A, "R10", "word after aborted partial", v, 16'h5A);
    rd(4'h6, v); chk(v[0] == 1, "R10", "done after full word", v[0], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_manual_en;
    t_master(0, 0, 8, 3'd1, 16'h00A5, 16'h003C, -1);
    t_master(1, 1, 5, 3'd0, 16'h0013, 16'h000A, -1);
    t_master(0, 1, 16, 3'd2, 16'hC3A1, 16'h5E07, -1);
    t_master(0, 0, 8, 3'd3, 16'h0096, 16'h0071, 12);
    t_interval;
    t_slave;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule